// File: doc/BRIEF.md
# Two-Entry Register File with Equality Flag

This block is the register storage of a small 16-bit processor with exactly two architectural registers, referred to here as register zero and register one. A single write port loads a shared data word into neither, either, or both registers on the rising clock edge, depending on a 2-bit destination code. Two read ports, port A and port B, return register contents combinationally. A 2-bit read-select code drives them: its low bit picks the register shown on port A, and its high bit picks the register shown on port B.

A status flag reports when the two read ports carry the same value. This lets a branch-on-equal decision be made without a pass through the ALU. Both register contents also appear on their own debug outputs. A synchronous reset clears both registers.

The write port is a plain register-file port with no valid/ready handshake. The core presents one write per cycle, and the block accepts every write without back-pressure. All pins are plain control, data and status signals.

Top module: `rf2_regfile`

## Requirements
- R1: When `rst` is high at a rising clock edge, both registers become zero, whatever `wr_code` holds in that cycle. All outputs therefore read zero after that edge, and `eq` reads 1.
- R2: `wr_code` = 2'b00 leaves both registers unchanged across the edge.
- R3: `wr_code` = 2'b01 loads `wr_data` into register zero at the edge and leaves register one unchanged.
- R4: `wr_code` = 2'b10 loads `wr_data` into register one at the edge and leaves register zero unchanged.
- R5: `wr_code` = 2'b11 loads the same `wr_data` into both registers at the same edge.
- R6: Port A (`rd_a_data`) shows register zero when `rd_sel[0]` is 0 and register one when `rd_sel[0]` is 1, combinationally.
- R7: Port B (`rd_b_data`) shows register zero when `rd_sel[1]` is 0 and register one when `rd_sel[1]` is 1, combinationally.
- R8: `eq` is 1 exactly when `rd_a_data` equals `rd_b_data`. It is therefore always 1 for `rd_sel` 2'b00 or 2'b11, and for 2'b01 or 2'b10 it is 1 only when the two registers hold equal values.
- R9: `dbg_reg0` and `dbg_reg1` always show the current contents of register zero and register one.
- R10: A write becomes visible on the read ports, `eq` and the debug outputs only after the clock edge that performs it. There is no write-to-read bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous reset, active high, takes priority over writes |
| wr_data | input | 16 | Data word for the write port |
| wr_code | input | 2 | Destination: 00 none, 01 register zero, 10 register one, 11 both |
| rd_sel | input | 2 | Bit 0 selects port A source, bit 1 selects port B source |
| rd_a_data | output | 16 | Read port A value |
| rd_b_data | output | 16 | Read port B value |
| eq | output | 1 | High when the two read port values are identical |
| dbg_reg0 | output | 16 | Contents of register zero |
| dbg_reg1 | output | 16 | Contents of register one |

## Verification
The bench walks all sixteen pairings of destination code and read select. A design that swapped the select bits, or decoded the write code as a one-hot index, would put the wrong register on a port or miss the second register on the dual write. Reset is asserted together with a dual write; a design that gave the write priority would come out of reset holding data instead of zeros.

The equality flag is checked with cross selects on registers that differ and on registers made equal by a dual write. This exposes a flag that only decodes the select code and never compares data. Read ports are also sampled just before the writing edge, which catches any bypass path that shows new data early.

// File: rtl/rf2_pkg.sv
package rf2_pkg;
  localparam int unsigned NUM_REGS = 2;
  localparam int unsigned SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  typedef enum logic [1:0] {
    WR_NONE = 2'b00,
    WR_R0   = 2'b01,
    WR_R1   = 2'b10,
    WR_BOTH = 2'b11
  } wr_code_e;
endpackage

// File: rtl/rf2_wr_decode.sv
module rf2_wr_decode
  import rf2_pkg::*;
(
  input  logic [1:0]          wr_code,
  output logic [NUM_REGS-1:0] wr_en
);
  // each bit of the destination code enables the register of the same index
  always_comb begin
    unique case (wr_code_e'(wr_code))
      WR_NONE: wr_en = 2'b00;
      WR_R0:   wr_en = 2'b01;
      WR_R1:   wr_en = 2'b10;
      WR_BOTH: wr_en = 2'b11;
      default: wr_en = 2'b00;
    endcase
  end
endmodule

// File: rtl/rf2_store.sv
module rf2_store
  import rf2_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_REGS-1:0]              wr_en,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)            regs_q[gi] <= '0;
      else if (wr_en[gi]) regs_q[gi] <= wr_data;
    end
  end
endmodule

// File: rtl/rf2_read_port.sv
module rf2_read_port
  import rf2_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [SEL_W-1:0]                sel,
  output logic [DATA_W-1:0]               data
);
  always_comb data = regs[sel];
endmodule

// File: rtl/rf2_eq_cmp.sv
module rf2_eq_cmp #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              same
);
  always_comb same = (a == b);
endmodule

// File: rtl/rf2_regfile.sv
module rf2_regfile
  import rf2_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_code,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              eq,
  output logic [DATA_W-1:0] dbg_reg0,
  output logic [DATA_W-1:0] dbg_reg1
);
  localparam int unsigned NUM_PORTS = 2;

  logic [NUM_REGS-1:0]              wr_en;
  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q;
  logic [NUM_PORTS-1:0][DATA_W-1:0] port_data;

  rf2_wr_decode u_dec (
    .wr_code (wr_code),
    .wr_en   (wr_en)
  );

  rf2_store #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .regs_q  (regs_q)
  );

  // select bit p steers read port p (port 0 = A, port 1 = B)
  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
    rf2_read_port #(.DATA_W(DATA_W)) u_rd (
      .regs (regs_q),
      .sel  (rd_sel[gp +: SEL_W]),
      .data (port_data[gp])
    );
  end

  rf2_eq_cmp #(.DATA_W(DATA_W)) u_eq (
    .a    (port_data[0]),
    .b    (port_data[1]),
    .same (eq)
  );

  assign rd_a_data = port_data[0];
  assign rd_b_data = port_data[1];
  assign dbg_reg0  = regs_q[0];
  assign dbg_reg1  = regs_q[1];
endmodule

// File: rtl/rf2_regfile_chk.sv
module rf2_regfile_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        wr_code,
  input logic [1:0]        rd_sel,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              eq,
  input logic [DATA_W-1:0] dbg_reg0,
  input logic [DATA_W-1:0] dbg_reg1
);
  logic rst_seen_q = 1'b0;
  always_ff @(posedge clk) rst_seen_q <= rst;

  always @(posedge clk) begin
    if (rst_seen_q) begin
      AST_RESET_CLEARS: assert (dbg_reg0 == '0 && dbg_reg1 == '0); // R1
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    wr_code == 2'b00 |=> $stable(dbg_reg0) && $stable(dbg_reg1)); // R2

  AST_WRITE_R0: assert property (@(posedge clk) disable iff (rst)
    wr_code == 2'b01 |=> dbg_reg0 == $past(wr_data) && $stable(dbg_reg1)); // R3

  AST_WRITE_R1: assert property (@(posedge clk) disable iff (rst)
    wr_code == 2'b10 |=> dbg_reg1 == $past(wr_data) && $stable(dbg_reg0)); // R4

  AST_WRITE_BOTH: assert property (@(posedge clk) disable iff (rst)
    wr_code == 2'b11 |=> dbg_reg0 == $past(wr_data) && dbg_reg1 == $past(wr_data)); // R5

  AST_SAME_SEL_EQ: assert property (@(posedge clk) disable iff (rst)
    rd_sel[0] == rd_sel[1] |-> eq); // R8
endmodule

bind rf2_regfile rf2_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_data   (wr_data),
  .wr_code   (wr_code),
  .rd_sel    (rd_sel),
  .rd_a_data (rd_a_data),
  .rd_b_data (rd_b_data),
  .eq        (eq),
  .dbg_reg0  (dbg_reg0),
  .dbg_reg1  (dbg_reg1)
);

// File: tb/rf2_regfile_test.sv
`timescale 1ns/1ps
module rf2_regfile_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   wr_code = 2'b00;
  logic [1:0]   rd_sel  = 2'b00;
  logic [W-1:0] rd_a_data, rd_b_data, dbg_reg0, dbg_reg1;
  logic         eq;

  always #10 clk = ~clk;  // 50 MHz

  rf2_regfile uut (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_code(wr_code),
    .rd_sel(rd_sel), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .eq(eq), .dbg_reg0(dbg_reg0), .dbg_reg1(dbg_reg1)
  );

  typedef struct {
    logic [W-1:0] r0, r1, a, b;
    logic         e;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  logic [W-1:0] m0 = '0, m1 = '0;
  bit   drv_done = 1'b0;

  function automatic exp_t make_exp(logic [1:0] sel, string tag);
    exp_t x;
    x.r0 = m0; x.r1 = m1;
    x.a  = sel[0] ? m1 : m0;
    x.b  = sel[1] ? m1 : m0;
    x.e  = (x.a == x.b);
    x.tag = tag;
    return x;
  endfunction

  function automatic void compare(exp_t x, string when);
    n_checks++;
    if (dbg_reg0 !== x.r0 || dbg_reg1 !== x.r1 || rd_a_data !== x.a ||
        rd_b_data !== x.b || eq !== x.e) begin
      n_fail++;
      $display("FAIL %s %s: got r0=%h r1=%h a=%h b=%h eq=%b exp r0=%h r1=%h a=%h b=%h eq=%b",
               x.tag, when, dbg_reg0, dbg_reg1, rd_a_data, rd_b_data, eq,
               x.r0, x.r1, x.a, x.b, x.e);
    end
  endfunction

  // driver: one cycle of stimulus, queues the state expected after the edge
  task automatic apply(logic r, logic [1:0] code, logic [W-1:0] d,
                       logic [1:0] sel, string tag);
    @(negedge clk);
    rst = r; wr_code = code; wr_data = d; rd_sel = sel;
    #1;
    if (!r) compare(make_exp(sel, "R10"), "before edge");  // R10 no bypass
    if (r) begin m0 = '0; m1 = '0; end
    else begin
      if (code[0]) m0 = d;
      if (code[1]) m1 = d;
    end
    exp_q.push_back(make_exp(sel, tag));
    @(posedge clk);
  endtask

  // monitor: pops and compares a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), "after edge");
    end
  end

  initial begin
    apply(1'b1, 2'b00, 16'h0000, 2'b00, "R1");
    apply(1'b0, 2'b01, 16'h1234, 2'b01, "R3/R6/R7/R8/R9");
    apply(1'b0, 2'b10, 16'hA5C3, 2'b10, "R4/R6/R7/R8/R9");
    // R1 reset beats a dual write in the same cycle
    apply(1'b1, 2'b11, 16'hFFFF, 2'b01, "R1");
    // all sixteen pairings of write code and read select
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 4; s++) begin
        string t;
        logic [W-1:0] d;
        d = 16'(16'h1000 * (c + 1) + 16'h0111 * (s + 1) + c * s);
        case (c)
          0: t = "R2/R6/R7/R8";
          1: t = "R3/R6/R7/R8";
          2: t = "R4/R6/R7/R8";
          default: t = "R5/R6/R7/R8";
        endcase
        apply(1'b0, 2'(c), d, 2'(s), t);
      end
    end
    // R5 then R8: equal registers make cross selects report equality
    apply(1'b0, 2'b11, 16'h7E81, 2'b01, "R5/R8");
    apply(1'b0, 2'b00, 16'h0000, 2'b10, "R2/R8");
    // R8: differing registers on cross select clear the flag
    apply(1'b0, 2'b01, 16'h0001, 2'b01, "R3/R8");
    apply(1'b0, 2'b10, 16'h8000, 2'b10, "R4/R8");
    apply(1'b0, 2'b00, 16'hDEAD, 2'b11, "R2/R8/R9");
    apply(1'b1, 2'b00, 16'h0000, 2'b01, "R1/R8");
    @(posedge clk); #6;
    drv_done = 1'b1;
  end

  initial begin
    fork
      wait (drv_done);
      begin
        #(20 * 5000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule